// File: doc/BRIEF.md
# PS/2 Scan-Code Receiver

This block listens to a PS/2 keyboard on the two open-collector lines (clock and data), both of which rest at logic High between transfers. The lines are brought into the system clock domain through two-flop synchronisers. A short glitch filter then cleans the clock, and each falling edge of the filtered clock samples one bit. A frame state machine collects 11-bit frames and checks their framing and parity. A small decoder then folds the extended (E0) and release (F0) prefix bytes into the key event that follows them.

The user sees one key event per non-prefix byte. Each event is a single-cycle strobe together with the final scan code, a break (key released) flag and an extended flag. Malformed frames raise a single-cycle error flag instead and discard any pending prefix. Auto-repeat from a held key shows up as a fresh make event for every repeated code.

The frame state machine has four states. `RX_IDLE` waits for a start bit. `RX_DATA` shifts in eight data bits, least significant first. `RX_PARITY` captures the parity bit. `RX_STOP` checks the stop bit and the parity. Its transitions are:
- start: `RX_IDLE`→`RX_DATA`, on a falling edge with data low.
- byte_full: `RX_DATA`→`RX_PARITY`, after the eighth data bit.
- parity_taken: `RX_PARITY`→`RX_STOP`.
- frame_end: `RX_STOP`→`RX_IDLE`.
- abort: any state other than `RX_IDLE`→`RX_IDLE`, when `TIMEOUT_CYC` system cycles pass with no falling edge.

Top module: `ps2_key_rx`

## Requirements
- R1: After reset, `key_stb`, `key_break`, `key_ext` and `frame_err` are 0 and `key_code` is 0x00.
- R2: A frame with start bit 0, eight data bits sent least significant bit first, odd parity over data and parity bit, and stop bit 1 carrying a byte other than 0xE0 or 0xF0 produces exactly one `key_stb` pulse, with `key_code` equal to that byte.
- R3: A frame whose parity bit makes the count of ones over the eight data bits and the parity bit even produces a `frame_err` pulse and no `key_stb`.
- R4: A stop bit of 0 produces a `frame_err` pulse and no event. A falling clock edge seen in `RX_IDLE` with data high (a bad start bit) also produces a `frame_err` pulse.
- R5: The byte 0xF0 produces no event of its own. The next non-prefix byte is reported with `key_break`=1.
- R6: The byte 0xE0 produces no event of its own. The next non-prefix byte is reported with `key_ext`=1. The sequence E0, F0, code reports both flags as 1.
- R7: Pending prefix flags apply to one event only. The event after that carries `key_break`=0 and `key_ext`=0 unless new prefixes arrive.
- R8: A frame error discards any pending prefix, so the next code is reported with both flags 0.
- R9: Receiving the same make code repeatedly produces one make event per reception.
- R10: Inside a frame, a gap of exactly `TIMEOUT_CYC` cycles between falling edges is accepted. A gap of `TIMEOUT_CYC`+1 aborts the frame to `RX_IDLE` with no event.
- R11: A clock low pulse shorter than `FILT_LEN` system cycles is ignored: it produces no error and no event.
- R12: `key_stb` and `frame_err` are each high for one cycle per report and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk | input | 1 | PS/2 clock line from the keyboard |
| ps2_dat | input | 1 | PS/2 data line from the keyboard |
| key_stb | output | 1 | One-cycle key event strobe |
| key_code | output | 8 | Scan code of the last event |
| key_break | output | 1 | Last event was a key release |
| key_ext | output | 1 | Last event was an extended key |
| frame_err | output | 1 | One-cycle malformed-frame pulse |

## Verification
The inactivity timeout and the arrival of a falling clock edge can land in the same system cycle. When they do, the edge wins and the frame continues. The bench provokes this by stretching the gap before the stop bit to exactly `TIMEOUT_CYC` cycles, which must yield a normal event. It then stretches the gap one cycle longer, which must abort the frame. In that case the late stop edge is seen in `RX_IDLE` as a bad start bit, so exactly one `frame_err` and no event are expected.

// File: rtl/ps2kb_pkg.sv
package ps2kb_pkg;
    typedef enum logic [1:0] {
        RX_IDLE,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_t;

    localparam logic [7:0] CODE_EXT = 8'hE0;
    localparam logic [7:0] CODE_BRK = 8'hF0;
    localparam int         DATA_BITS = 8;
endpackage

// File: rtl/ps2kb_line_filter.sv
module ps2kb_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ps2_clk_i,
    input  logic ps2_dat_i,
    output logic fall_o,
    output logic dat_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    clk_s;
    logic [1:0]    dat_s;
    logic          clk_f;
    logic          clk_f_d;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_s   <= 2'b11;
            dat_s   <= 2'b11;
            clk_f   <= 1'b1;
            clk_f_d <= 1'b1;
            cnt     <= '0;
        end else begin
            clk_s   <= {clk_s[0], ps2_clk_i};
            dat_s   <= {dat_s[0], ps2_dat_i};
            clk_f_d <= clk_f;
            if (clk_s[1] == clk_f) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_LEN - 1)) begin
                clk_f <= clk_s[1];
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign fall_o = clk_f_d & ~clk_f;
    assign dat_o  = dat_s[1];

    // R11
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_f) |-> ($past(clk_s[1]) != $past(clk_f)));
endmodule

// File: rtl/ps2kb_frame_rx.sv
module ps2kb_frame_rx
    import ps2kb_pkg::*;
#(
    parameter int TIMEOUT_CYC = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fall_i,
    input  logic       dat_i,
    output logic       byte_vld_o,
    output logic [7:0] byte_o,
    output logic       err_o
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam int BW = $clog2(DATA_BITS);

    rx_state_t     st, st_nx;
    logic [TW-1:0] gap_cnt;
    logic [BW-1:0] bit_cnt;
    logic [7:0]    shreg;
    logic          par_q;
    logic          frame_ok;

    assign frame_ok = dat_i & (^{shreg, par_q});

    always_comb begin
        st_nx = st;
        if (st != RX_IDLE && !fall_i && gap_cnt == TW'(TIMEOUT_CYC - 1)) begin
            st_nx = RX_IDLE;
        end else if (fall_i) begin
            unique case (st)
                RX_IDLE:   if (!dat_i) st_nx = RX_DATA;
                RX_DATA:   if (bit_cnt == BW'(DATA_BITS - 1)) st_nx = RX_PARITY;
                RX_PARITY: st_nx = RX_STOP;
                RX_STOP:   st_nx = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
            par_q   <= 1'b0;
        end else begin
            if (fall_i || st == RX_IDLE) gap_cnt <= '0;
            else                         gap_cnt <= gap_cnt + 1'b1;
            if (st == RX_IDLE)                bit_cnt <= '0;
            else if (fall_i && st == RX_DATA) bit_cnt <= bit_cnt + 1'b1;
            if (fall_i && st == RX_DATA)   shreg <= {dat_i, shreg[7:1]};
            if (fall_i && st == RX_PARITY) par_q <= dat_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_vld_o <= 1'b0;
            byte_o     <= '0;
            err_o      <= 1'b0;
        end else begin
            byte_vld_o <= fall_i && st == RX_STOP && frame_ok;
            err_o      <= fall_i && ((st == RX_IDLE && dat_i) ||
                                     (st == RX_STOP && !frame_ok));
            if (fall_i && st == RX_STOP) byte_o <= shreg;
        end
    end

    // R2
    byte_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> (st == RX_IDLE));
    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != RX_IDLE && !fall_i && gap_cnt == TW'(TIMEOUT_CYC - 1))
        |=> (st == RX_IDLE && !byte_vld_o && !err_o));
endmodule

// File: rtl/ps2kb_code_fold.sv
module ps2kb_code_fold
    import ps2kb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld_i,
    input  logic [7:0] byte_i,
    input  logic       err_i,
    output logic       key_stb_o,
    output logic [7:0] key_code_o,
    output logic       key_brk_o,
    output logic       key_ext_o,
    output logic       err_o
);
    logic pend_ext, pend_brk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_ext   <= 1'b0;
            pend_brk   <= 1'b0;
            key_stb_o  <= 1'b0;
            key_code_o <= '0;
            key_brk_o  <= 1'b0;
            key_ext_o  <= 1'b0;
            err_o      <= 1'b0;
        end else begin
            key_stb_o <= 1'b0;
            err_o     <= err_i;
            if (err_i) begin
                pend_ext <= 1'b0;
                pend_brk <= 1'b0;
            end else if (byte_vld_i) begin
                if (byte_i == CODE_EXT) begin
                    pend_ext <= 1'b1;
                end else if (byte_i == CODE_BRK) begin
                    pend_brk <= 1'b1;
                end else begin
                    key_stb_o  <= 1'b1;
                    key_code_o <= byte_i;
                    key_brk_o  <= pend_brk;
                    key_ext_o  <= pend_ext;
                    pend_ext   <= 1'b0;
                    pend_brk   <= 1'b0;
                end
            end
        end
    end

    // R12
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_stb_o |=> !key_stb_o);
    // R12
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(key_stb_o && err_o));
    // R8
    err_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |=> (!pend_ext && !pend_brk && !key_stb_o));
    // R6
    ext_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && !err_i && byte_i == CODE_EXT) |=> (pend_ext && !key_stb_o));
endmodule

// File: rtl/ps2_key_rx.sv
module ps2_key_rx #(
    parameter int FILT_LEN    = 4,
    parameter int TIMEOUT_CYC = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk,
    input  logic       ps2_dat,
    output logic       key_stb,
    output logic [7:0] key_code,
    output logic       key_break,
    output logic       key_ext,
    output logic       frame_err
);
    logic       fall, dat;
    logic       byte_vld, byte_err;
    logic [7:0] byte_val;

    ps2kb_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n),
        .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
        .fall_o(fall), .dat_o(dat)
    );

    ps2kb_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .fall_i(fall), .dat_i(dat),
        .byte_vld_o(byte_vld), .byte_o(byte_val), .err_o(byte_err)
    );

    ps2kb_code_fold u_fold (
        .clk(clk), .rst_n(rst_n),
        .byte_vld_i(byte_vld), .byte_i(byte_val), .err_i(byte_err),
        .key_stb_o(key_stb), .key_code_o(key_code),
        .key_brk_o(key_break), .key_ext_o(key_ext), .err_o(frame_err)
    );
endmodule

// File: tb/tb_ps2_key_rx.sv
`timescale 1ns/1ps
module tb_ps2_key_rx;
    localparam int FILT = 4;
    localparam int TMO  = 400;
    localparam int H    = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ps2c = 1'b1;
    logic ps2d = 1'b1;
    logic       key_stb, key_break, key_ext, frame_err;
    logic [7:0] key_code;

    int n_chk = 0, n_fail = 0;
    int evt_cnt = 0, err_cnt = 0, bad_pulse = 0;
    logic [7:0] last_code;
    logic last_brk, last_ext, prev_stb = 1'b0, prev_err = 1'b0;
    bit m_ext = 0, m_brk = 0;

    always #4 clk = ~clk;

    ps2_key_rx #(.FILT_LEN(FILT), .TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .ps2_clk(ps2c), .ps2_dat(ps2d),
        .key_stb(key_stb), .key_code(key_code), .key_break(key_break),
        .key_ext(key_ext), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (key_stb) begin
            evt_cnt++; last_code = key_code; last_brk = key_break; last_ext = key_ext;
        end
        if (frame_err) err_cnt++;
        if ((key_stb && frame_err) || (key_stb && prev_stb) || (frame_err && prev_err))
            bad_pulse++;
        prev_stb = key_stb; prev_err = frame_err;
    end

    task automatic check(input bit ok, input string req, input string detail);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, detail);
        end
    endtask

    function automatic logic [10:0] mk_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop);
        return {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [10:0] bits, input int hi_last);
        for (int i = 0; i < 11; i++) begin
            ps2d = bits[i];
            wait_cyc((i == 10) ? hi_last : H);
            ps2c = 1'b0;
            wait_cyc(H);
            ps2c = 1'b1;
        end
        ps2d = 1'b1;
        wait_cyc(60);
    endtask

    task automatic xfer(input logic [7:0] b, input bit bad_par, input bit bad_stop, input string req);
        int e0, r0;
        bit x_evt, x_err, x_brk, x_ext;
        e0 = evt_cnt; r0 = err_cnt;
        send(mk_frame(b, bad_par, bad_stop), H);
        x_evt = 0; x_err = 0; x_brk = 0; x_ext = 0;
        if (bad_par || bad_stop) begin
            x_err = 1; m_ext = 0; m_brk = 0;
        end else if (b == 8'hE0) m_ext = 1;
        else if (b == 8'hF0) m_brk = 1;
        else begin
            x_evt = 1; x_brk = m_brk; x_ext = m_ext; m_ext = 0; m_brk = 0;
        end
        check((evt_cnt - e0) == int'(x_evt) && (err_cnt - r0) == int'(x_err), req,
              $sformatf("byte %h events %0d errors %0d, expected %0d/%0d",
                        b, evt_cnt - e0, err_cnt - r0, x_evt, x_err));
        if (x_evt)
            check(last_code == b && last_brk == x_brk && last_ext == x_ext, req,
                  $sformatf("code/brk/ext %h/%0d/%0d, expected %h/%0d/%0d",
                            last_code, last_brk, last_ext, b, x_brk, x_ext));
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int e0, r0;
        void'($urandom(32'd2024));
        wait_cyc(5);
        check(!key_stb && !key_break && !key_ext && !frame_err && key_code == 8'h00, "R1",
              $sformatf("outputs %0d%0d%0d%0d %h, expected 0000 00",
                        key_stb, key_break, key_ext, frame_err, key_code));
        rst_n = 1'b1;
        wait_cyc(10);
        check(!key_stb && !frame_err, "R1", "strobes active after reset, expected idle");

        xfer(8'h1C, 0, 0, "R2");
        xfer(8'h1C, 0, 0, "R9");
        xfer(8'h1C, 0, 0, "R9");
        xfer(8'hF0, 0, 0, "R5");
        xfer(8'h1C, 0, 0, "R5");
        xfer(8'h32, 0, 0, "R7");
        xfer(8'hE0, 0, 0, "R6");
        xfer(8'h75, 0, 0, "R6");
        xfer(8'hE0, 0, 0, "R6");
        xfer(8'hF0, 0, 0, "R6");
        xfer(8'h75, 0, 0, "R6");
        xfer(8'h75, 0, 0, "R7");
        xfer(8'h4B, 1, 0, "R3");
        xfer(8'hE0, 0, 0, "R8");
        xfer(8'hF0, 0, 0, "R8");
        xfer(8'h4B, 0, 1, "R4");
        xfer(8'h4B, 0, 0, "R8");

        // R4: bad start bit, clock falls with data high while idle
        e0 = evt_cnt; r0 = err_cnt;
        ps2d = 1'b1; ps2c = 1'b0; wait_cyc(H); ps2c = 1'b1; wait_cyc(60);
        check(err_cnt - r0 == 1 && evt_cnt == e0, "R4",
              $sformatf("bad start errors %0d events %0d, expected 1/0", err_cnt - r0, evt_cnt - e0));

        // R11: short glitches on the clock line
        e0 = evt_cnt; r0 = err_cnt;
        ps2c = 1'b0; wait_cyc(FILT - 2); ps2c = 1'b1; wait_cyc(20);
        ps2c = 1'b0; wait_cyc(1); ps2c = 1'b1; wait_cyc(20);
        check(err_cnt == r0 && evt_cnt == e0, "R11",
              $sformatf("glitch errors %0d events %0d, expected 0/0", err_cnt - r0, evt_cnt - e0));
        xfer(8'h29, 0, 0, "R11");

        // R10: final gap of exactly TMO cycles is accepted
        e0 = evt_cnt; r0 = err_cnt;
        send(mk_frame(8'h5A, 0, 0), TMO - H);
        check(evt_cnt - e0 == 1 && err_cnt == r0 && last_code == 8'h5A, "R10",
              $sformatf("gap=limit events %0d code %h, expected 1 5a", evt_cnt - e0, last_code));
        // R10: one cycle longer aborts; late stop edge counts as bad start
        xfer(8'hE0, 0, 0, "R10");
        e0 = evt_cnt; r0 = err_cnt;
        send(mk_frame(8'h5A, 0, 0), TMO - H + 1);
        m_ext = 0; m_brk = 0;
        check(evt_cnt == e0 && err_cnt - r0 == 1, "R10",
              $sformatf("gap=limit+1 events %0d errors %0d, expected 0/1", evt_cnt - e0, err_cnt - r0));
        xfer(8'h5A, 0, 0, "R10");

        for (int k = 0; k < 40; k++) begin
            int kind;
            logic [7:0] b;
            kind = int'($urandom % 7);
            b = 8'($urandom % 8'h83) + 8'h01;
            case (kind)
                0: xfer(8'hE0, 0, 0, "R6");
                1: xfer(8'hF0, 0, 0, "R5");
                2: xfer(b, 1, 0, "R3");
                3: xfer(b, 0, ($urandom % 4) == 0, "R4");
                default: xfer(b, 0, 0, "R2");
            endcase
        end

        check(bad_pulse == 0, "R12",
              $sformatf("pulse violations %0d, expected 0", bad_pulse));
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule